// File: doc/BRIEF.md
# Receive Frame Record Writer

This block takes an incoming Ethernet frame as a byte stream and stores it as a formatted record in one page of packet memory. On the first byte of a frame it asks a page allocator for a free page. If receive is enabled, soft reset is not active and a page is granted, the data bytes are written into the page as they arrive. When the last byte has been taken, the block adds zero padding for short frames and an optional CRC-32. It then writes a two-byte trailer, and finally a status word and a byte count at the start of the page. It then pushes the page number onto the receive queue and raises the receive interrupt for one cycle.

Record layout, by byte offset in the page: status word at 0..1 and byte count at 2..3, both little-endian. The data area starts at offset 4. For frames of at least 64 bytes it holds the even part of the frame, and for shorter frames it holds 64 bytes. The CRC follows when it is kept, then the two trailer bytes. The input stream has no backpressure. A frame must therefore not start before the previous record has been completed, and a frame that breaks this rule is discarded whole.

The controller is a state machine with these states: IDLE (wait for a first byte; take it, refuse it, or skip), DATA (take data bytes), SKIP (discard a refused frame up to its last byte), OVER (discard the rest of a frame that grew too long, then give its page back), PAD (write zero bytes), CRC (write four CRC bytes), TAIL (write two trailer bytes), HDR (write status and count) and DONE (push and interrupt). The transitions are: IDLE→DATA on an accepted first byte; IDLE→PAD on an accepted one-byte frame; IDLE→SKIP on a refused byte that is not last. DATA→PAD, DATA→CRC or DATA→TAIL on the last byte, depending on length and strip mode. DATA→OVER on a byte that makes the record too long; DATA→IDLE when that byte is also the last. SKIP→IDLE and OVER→IDLE on a last byte. PAD→CRC or PAD→TAIL once offset 67 is written. CRC→TAIL after four bytes. TAIL→HDR after two bytes. HDR→DONE after four bytes. DONE→IDLE, or DONE→SKIP when a frame that started during completion is still running.

Top module: `rx_frame_writer`

## Requirements
- R1: While `rx_enable` is low or `rx_soft_reset` is high when a frame's first byte arrives, the whole frame is refused: no allocation request, no memory write, no push.
- R2: When the allocator answers a request with `alloc_ok` low, the frame is refused: no memory write and no push.
- R3: The byte count at offsets 2 (low) and 3 (high) is 64 for frames shorter than 64 bytes and the frame length with bit 0 cleared otherwise, plus 6, plus 4 more when `strip_crc` was low at the first byte.
- R4: The status word at offsets 0 (low) and 1 (high) has bit 11 set when the frame length exceeds 1518 and bit 12 set when the length is odd; all other bits are zero.
- R5: Data bytes are written in arrival order from offset 4. A frame shorter than 64 bytes is stored whole, including any odd last byte, and zero-filled up to offset 67. A longer frame stores its even part only. Each record byte is written exactly once, and all writes of a frame go to the granted page.
- R6: Unless `strip_crc` was high at the first byte, four CRC bytes follow the data area, least significant byte first. The CRC uses the reflected polynomial 0xEDB88320 with the register cleared to zero at frame start. It consumes each byte least significant bit first, covers every data byte (pad zeros and a held odd byte included), and is stored complemented.
- R7: The record ends with two bytes: for a frame of at least 64 bytes with odd length, the last data byte then 0x60; otherwise 0x00 then 0x40.
- R8: A frame whose byte count would exceed 2048 is not pushed. Its page is handed back on `pg_ret_valid`/`pg_ret_page` in the cycle that takes its last byte.
- R9: The status and count are the last bytes written. `rxq_push` and `rx_irq` pulse together for one cycle with the page number, P+C+6 cycles after the edge that takes the last byte. P is the number of pad bytes and C is 4 or 0.
- R10: Bytes that arrive while a record is being completed are discarded together with the rest of their frame.
- R11: After reset, all request, write, return, push and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_enable | input | 1 | Receive enable |
| rx_soft_reset | input | 1 | Soft reset held; frames refused |
| strip_crc | input | 1 | Omit CRC from the record, sampled at a frame's first byte |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the frame's last byte |
| alloc_req | output | 1 | Page request, combinational on a first byte |
| alloc_ok | input | 1 | Allocator has a page for the request |
| alloc_page | input | PAGE_W | Granted page number |
| mem_we | output | 1 | Memory byte write strobe |
| mem_page | output | PAGE_W | Page being written |
| mem_addr | output | ADDR_W | Byte offset in the page |
| mem_wdata | output | 8 | Byte written |
| pg_ret_valid | output | 1 | Page handed back after an oversize frame |
| pg_ret_page | output | PAGE_W | Page handed back |
| rxq_push | output | 1 | Push a completed page onto the receive queue |
| rxq_page | output | PAGE_W | Page pushed |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
Every result is tied to a cycle. A first-byte write and the allocation request appear in the same cycle as the byte. Completion comes exactly P+C+6 cycles after the edge that takes the last byte. The bench counts cycles from that edge and requires the push, the page number and the interrupt at exactly that count. It samples one time unit after each edge, by which point all record writes have been recorded. For refusals, oversize drops and stray frames, the bench waits well beyond the longest completion window, then compares write, push and page-return counts.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
    typedef enum logic [3:0] {
        RX_IDLE, RX_DATA, RX_SKIP, RX_OVER, RX_PAD,
        RX_CRC, RX_TAIL, RX_HDR, RX_DONE
    } rxw_state_e;

    localparam int HDR_BYTES    = 4;
    localparam int TAIL_BYTES   = 2;
    localparam int CRC_BYTES    = 4;
    localparam int STAT_LONG_BIT = 11;
    localparam int STAT_ODD_BIT  = 12;
    localparam logic [7:0] TAIL_MARK_ODD  = 8'h60;
    localparam logic [7:0] TAIL_MARK_EVEN = 8'h40;
endpackage

// File: rtl/rxw_crc.sv
module rxw_crc #(
    parameter logic [31:0] POLY = 32'hEDB88320
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] crc_q
);
    logic [31:0] acc;

    // one byte per cycle, bit 0 first; start restarts from zero
    always_comb begin
        acc = (start ? 32'd0 : crc_q) ^ {24'd0, din};
        for (int b = 0; b < 8; b++) begin
            acc = acc[0] ? ((acc >> 1) ^ POLY) : (acc >> 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  crc_q <= '0;
        else if (en) crc_q <= acc;
    end
endmodule

// File: rtl/rxw_hdr.sv
module rxw_hdr
    import rxw_pkg::*;
#(
    parameter int MIN_FRAME  = 64,
    parameter int LONG_LIMIT = 1518,
    parameter int LEN_W      = 13
) (
    input  logic [LEN_W-1:0] len,
    input  logic             strip,
    output logic [15:0]      count,
    output logic [15:0]      status,
    output logic             long_odd
);
    logic [LEN_W-1:0] len_even;
    logic [LEN_W-1:0] body;
    logic             is_short;

    always_comb begin
        len_even = {len[LEN_W-1:1], 1'b0};
        is_short = len < LEN_W'(MIN_FRAME);
        body     = is_short ? LEN_W'(MIN_FRAME) : len_even;
        count    = 16'(body) + 16'(HDR_BYTES + TAIL_BYTES)
                 + (strip ? 16'd0 : 16'(CRC_BYTES));
        status   = '0;
        status[STAT_LONG_BIT] = len > LEN_W'(LONG_LIMIT);
        status[STAT_ODD_BIT]  = len[0];
        long_odd = len[0] && !is_short;
    end
endmodule

// File: rtl/rx_frame_writer.sv
module rx_frame_writer
    import rxw_pkg::*;
#(
    parameter int PAGE_BYTES = 2048,
    parameter int PAGE_W     = 2,
    parameter int MIN_FRAME  = 64,
    parameter int LONG_LIMIT = 1518,
    localparam int ADDR_W    = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              rx_soft_reset,
    input  logic              strip_crc,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              alloc_req,
    input  logic              alloc_ok,
    input  logic [PAGE_W-1:0] alloc_page,
    output logic              mem_we,
    output logic [PAGE_W-1:0] mem_page,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              pg_ret_valid,
    output logic [PAGE_W-1:0] pg_ret_page,
    output logic              rxq_push,
    output logic [PAGE_W-1:0] rxq_page,
    output logic              rx_irq
);
    localparam int LEN_W         = ADDR_W + 2;
    localparam int MAX_EVEN_KEEP = PAGE_BYTES - HDR_BYTES - TAIL_BYTES - CRC_BYTES;
    localparam int MAX_EVEN_STRIP = PAGE_BYTES - HDR_BYTES - TAIL_BYTES;
    localparam int PAD_LAST      = HDR_BYTES + MIN_FRAME - 1;

    rxw_state_e        state_q, state_nx;
    logic [LEN_W-1:0]  nbytes_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [1:0]        idx_q;
    logic [PAGE_W-1:0] page_q;
    logic              strip_q;
    logic [7:0]        odd_q;
    logic              stray_q, stray_nx;

    logic              open_ok, accept;
    logic              strip_cur;
    logic [LEN_W-1:0]  cur_n, cur_even, max_even;
    logic              too_big, hold_odd, take_data, data_wr;
    logic              pad_done;
    rxw_state_e        end_state;
    logic              busy;

    logic [31:0]       crc_q;
    logic [31:0]       crc_out;
    logic              crc_start, crc_en;
    logic [7:0]        crc_din;
    logic [15:0]       hdr_count, hdr_status;
    logic              long_odd;

    rxw_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .start (crc_start),
        .en    (crc_en),
        .din   (crc_din),
        .crc_q (crc_q)
    );

    rxw_hdr #(
        .MIN_FRAME  (MIN_FRAME),
        .LONG_LIMIT (LONG_LIMIT),
        .LEN_W      (LEN_W)
    ) u_hdr (
        .len      (nbytes_q),
        .strip    (strip_q),
        .count    (hdr_count),
        .status   (hdr_status),
        .long_odd (long_odd)
    );

    // byte classification
    always_comb begin
        open_ok   = rx_enable && !rx_soft_reset;
        accept    = (state_q == RX_IDLE) && in_valid && open_ok && alloc_ok;
        strip_cur = (state_q == RX_IDLE) ? strip_crc : strip_q;
        cur_n     = (state_q == RX_IDLE) ? LEN_W'(1) : nbytes_q + LEN_W'(1);
        cur_even  = {cur_n[LEN_W-1:1], 1'b0};
        max_even  = strip_cur ? LEN_W'(MAX_EVEN_STRIP) : LEN_W'(MAX_EVEN_KEEP);
        too_big   = cur_even > max_even;
        hold_odd  = in_last && cur_n[0] && (cur_n >= LEN_W'(MIN_FRAME));
        take_data = accept || ((state_q == RX_DATA) && in_valid);
        data_wr   = take_data && !too_big && !hold_odd;
        pad_done  = ptr_q == ADDR_W'(PAD_LAST);
        busy      = state_q inside {RX_PAD, RX_CRC, RX_TAIL, RX_HDR, RX_DONE};
        stray_nx  = (busy && in_valid) ? !in_last : stray_q;
        if (cur_n < LEN_W'(MIN_FRAME)) end_state = RX_PAD;
        else if (strip_cur)            end_state = RX_TAIL;
        else                           end_state = RX_CRC;
        crc_start = accept;
        crc_en    = (take_data && !too_big) || (state_q == RX_PAD);
        crc_din   = (state_q == RX_PAD) ? 8'h00 : in_data;
        crc_out   = ~crc_q;
    end

    // next state
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            RX_IDLE: if (in_valid) begin
                if (accept)        state_nx = in_last ? end_state : RX_DATA;
                else if (!in_last) state_nx = RX_SKIP;
            end
            RX_DATA: if (in_valid) begin
                if (too_big)      state_nx = in_last ? RX_IDLE : RX_OVER;
                else if (in_last) state_nx = end_state;
            end
            RX_SKIP, RX_OVER: if (in_valid && in_last) state_nx = RX_IDLE;
            RX_PAD:  if (pad_done)      state_nx = strip_q ? RX_TAIL : RX_CRC;
            RX_CRC:  if (idx_q == 2'd3) state_nx = RX_TAIL;
            RX_TAIL: if (idx_q == 2'd1) state_nx = RX_HDR;
            RX_HDR:  if (idx_q == 2'd3) state_nx = RX_DONE;
            RX_DONE: state_nx = stray_nx ? RX_SKIP : RX_IDLE;
            default: state_nx = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nbytes_q <= '0;
            ptr_q    <= '0;
            idx_q    <= '0;
            page_q   <= '0;
            strip_q  <= 1'b0;
            odd_q    <= '0;
            stray_q  <= 1'b0;
        end else begin
            idx_q <= (state_nx != state_q) ? 2'd0 : idx_q + 2'd1;
            if (accept) begin
                page_q   <= alloc_page;
                strip_q  <= strip_crc;
                nbytes_q <= LEN_W'(1);
                ptr_q    <= ADDR_W'(HDR_BYTES + 1);
            end else if (state_q == RX_DATA) begin
                if (in_valid && !too_big) nbytes_q <= cur_n;
                if (data_wr)              ptr_q    <= ptr_q + ADDR_W'(1);
                if (in_valid && !too_big && hold_odd) odd_q <= in_data;
            end else if (state_q inside {RX_PAD, RX_CRC, RX_TAIL}) begin
                ptr_q <= ptr_q + ADDR_W'(1);
            end
            if (state_q == RX_DONE)       stray_q <= 1'b0;
            else if (busy && in_valid)    stray_q <= !in_last;
        end
    end

    // outputs
    always_comb begin
        alloc_req    = 1'b0;
        mem_we       = 1'b0;
        mem_page     = page_q;
        mem_addr     = ptr_q;
        mem_wdata    = 8'h00;
        pg_ret_valid = 1'b0;
        pg_ret_page  = page_q;
        rxq_push     = 1'b0;
        rxq_page     = page_q;
        rx_irq       = 1'b0;
        unique case (state_q)
            RX_IDLE: begin
                alloc_req = in_valid && open_ok;
                mem_we    = accept;
                mem_page  = alloc_page;
                mem_addr  = ADDR_W'(HDR_BYTES);
                mem_wdata = in_data;
            end
            RX_DATA: begin
                mem_we       = data_wr;
                mem_wdata    = in_data;
                pg_ret_valid = in_valid && too_big && in_last;
            end
            RX_OVER: pg_ret_valid = in_valid && in_last;
            RX_SKIP: ;
            RX_PAD:  mem_we = 1'b1;
            RX_CRC: begin
                mem_we    = 1'b1;
                mem_wdata = 8'(crc_out >> {idx_q, 3'b000});
            end
            RX_TAIL: begin
                mem_we = 1'b1;
                if (idx_q == 2'd0) mem_wdata = long_odd ? odd_q : 8'h00;
                else               mem_wdata = long_odd ? TAIL_MARK_ODD : TAIL_MARK_EVEN;
            end
            RX_HDR: begin
                mem_we   = 1'b1;
                mem_addr = ADDR_W'(idx_q);
                unique case (idx_q)
                    2'd0: mem_wdata = hdr_status[7:0];
                    2'd1: mem_wdata = hdr_status[15:8];
                    2'd2: mem_wdata = hdr_count[7:0];
                    2'd3: mem_wdata = hdr_count[15:8];
                    default: mem_wdata = 8'h00;
                endcase
            end
            RX_DONE: begin
                rxq_push = 1'b1;
                rx_irq   = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rxw_checker.sv
module rxw_checker #(
    parameter int PAGE_W = 2,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic              rx_soft_reset,
    input logic              in_valid,
    input logic              alloc_req,
    input logic              alloc_ok,
    input logic              mem_we,
    input logic [PAGE_W-1:0] mem_page,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              pg_ret_valid,
    input logic              rxq_push,
    input logic              rx_irq
);
    assert_alloc_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req |-> (in_valid && rx_enable && !rx_soft_reset));

    assert_grant_before_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && mem_we) |-> alloc_ok);

    assert_one_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_page == $past(mem_page)));

    assert_ret_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pg_ret_valid, rxq_push, mem_we}));

    assert_header_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |-> ($past(mem_we) && $past(mem_addr) == ADDR_W'(3)));

    assert_push_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rxq_push |=> !rxq_push);

    assert_irq_with_push_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_irq) |-> rxq_push);
endmodule

bind rx_frame_writer rxw_checker #(
    .PAGE_W (PAGE_W),
    .ADDR_W (ADDR_W)
) u_rxw_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_enable     (rx_enable),
    .rx_soft_reset (rx_soft_reset),
    .in_valid      (in_valid),
    .alloc_req     (alloc_req),
    .alloc_ok      (alloc_ok),
    .mem_we        (mem_we),
    .mem_page      (mem_page),
    .mem_addr      (mem_addr),
    .pg_ret_valid  (pg_ret_valid),
    .rxq_push      (rxq_push),
    .rx_irq        (rx_irq)
);

// File: tb/rx_frame_writer_bench.sv
`timescale 1ns/1ps
module rx_frame_writer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b0, rx_soft_reset = 1'b0, strip_crc = 1'b0;
    logic       in_valid = 1'b0, in_last = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       alloc_req, alloc_ok;
    logic [1:0] alloc_page;
    logic       mem_we;
    logic [1:0] mem_page;
    logic [10:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       pg_ret_valid;
    logic [1:0] pg_ret_page;
    logic       rxq_push;
    logic [1:0] rxq_page;
    logic       rx_irq;

    always #2.5 clk = ~clk;

    rx_frame_writer u_rx_frame_writer (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_soft_reset(rx_soft_reset),
        .strip_crc(strip_crc), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_page(alloc_page),
        .mem_we(mem_we), .mem_page(mem_page), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .pg_ret_valid(pg_ret_valid), .pg_ret_page(pg_ret_page),
        .rxq_push(rxq_push), .rxq_page(rxq_page), .rx_irq(rx_irq)
    );

    int total = 0, bad = 0;

    // allocator, memory and event models
    logic [3:0] used;
    logic       free_req = 1'b0, full_force = 1'b0, clr_req = 1'b0;
    logic [7:0] mem [0:2047];
    int         wr_cnt, push_cnt, irq_cnt, ret_cnt;
    logic [1:0] ret_page_cap;

    always_comb begin
        alloc_ok   = !full_force && (used != 4'hF);
        alloc_page = 2'd0;
        for (int i = 3; i >= 0; i--) if (!used[i]) alloc_page = 2'(i);
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used <= 4'h0; wr_cnt <= 0; push_cnt <= 0; irq_cnt <= 0; ret_cnt <= 0;
            ret_page_cap <= 2'd0;
        end else begin
            if (free_req) used <= 4'h0;
            else begin
                if (alloc_req && alloc_ok) used[alloc_page] <= 1'b1;
                if (pg_ret_valid) used[pg_ret_page] <= 1'b0;
            end
            if (clr_req) begin
                for (int i = 0; i < 2048; i++) mem[i] <= 8'hEE;
                wr_cnt <= 0;
            end else if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
            end
            if (rxq_push) push_cnt <= push_cnt + 1;
            if (rx_irq)   irq_cnt  <= irq_cnt + 1;
            if (pg_ret_valid) begin
                ret_cnt <= ret_cnt + 1;
                ret_page_cap <= pg_ret_page;
            end
        end
    end

    logic [7:0] fbuf [0:2047];
    logic [7:0] expb [0:2047];
    int exp_cnt, exp_data_len;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic pulse_ctl(input int which);
        if (which == 0) free_req = 1'b1; else clr_req = 1'b1;
        @(posedge clk); #1;
        free_req = 1'b0; clr_req = 1'b0;
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < 4; i++) if (!used[i]) return i;
        return 0;
    endfunction

    task automatic fill(input int len, input int seed);
        for (int i = 0; i < len; i++) fbuf[i] = 8'((i * 7 + seed) & 8'hFF);
    endtask

    // expected record from the requirements
    task automatic build_expected(input int len, input bit strip);
        logic [31:0] c;
        int p, body;
        logic [15:0] st;
        body = (len < 64) ? 64 : (len & ~1);
        exp_data_len = body;
        exp_cnt = body + 6 + (strip ? 0 : 4);
        st = 16'h0;
        if (len > 1518) st[11] = 1'b1;
        if (len % 2 == 1) st[12] = 1'b1;
        expb[0] = st[7:0]; expb[1] = st[15:8];
        expb[2] = 8'(exp_cnt & 255); expb[3] = 8'(exp_cnt >> 8);
        for (int i = 0; i < body; i++) expb[4 + i] = (i < len) ? fbuf[i] : 8'h00;
        c = 32'h0;
        for (int i = 0; i < ((len < 64) ? 64 : len); i++) begin
            c = c ^ {24'h0, ((i < len) ? fbuf[i] : 8'h00)};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        p = 4 + body;
        if (!strip) begin
            for (int k = 0; k < 4; k++) expb[p + k] = 8'(c >> (8 * k));
            p += 4;
        end
        if (len >= 64 && (len % 2 == 1)) begin
            expb[p] = fbuf[len - 1]; expb[p + 1] = 8'h60;
        end else begin
            expb[p] = 8'h00; expb[p + 1] = 8'h40;
        end
    endtask

    task automatic cmp_range(input int lo, input int hi, input string req, input string what);
        int miss = 0, at = -1;
        for (int i = lo; i < hi; i++)
            if (mem[i] !== expb[i]) begin miss++; if (at < 0) at = i; end
        if (at < 0) chk(1'b1, req, what, 0, 0);
        else chk(1'b0, req, $sformatf("%s byte %0d", what, at), int'(mem[at]), int'(expb[at]));
    endtask

    task automatic drive_byte(input logic [7:0] d, input bit last);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_last = last;
    endtask

    task automatic end_stream();
        @(posedge clk); #1;
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic check_record(input int len, input bit strip);
        cmp_range(0, 2, "R4", "status");
        cmp_range(2, 4, "R3", "count");
        cmp_range(4, 4 + exp_data_len, "R5", "data");
        if (!strip) cmp_range(4 + exp_data_len, 8 + exp_data_len, "R6", "crc");
        cmp_range(exp_cnt - 2, exp_cnt, "R7", "trailer");
        chk(wr_cnt == exp_cnt, "R5", "write count", wr_cnt, exp_cnt);
    endtask

    // normal frame: content, latency, push, interrupt
    task automatic t_frame(input int len, input bit strip, input int seed);
        int lat, exp_lat, pg, irq0;
        if (used == 4'hF) pulse_ctl(0);
        pulse_ctl(1);
        pg = lowest_free();
        strip_crc = strip;
        fill(len, seed);
        build_expected(len, strip);
        irq0 = irq_cnt;
        for (int i = 0; i < len; i++) drive_byte(fbuf[i], i == len - 1);
        end_stream();
        exp_lat = ((len < 64) ? 64 - len : 0) + (strip ? 0 : 4) + 6;
        lat = 0;
        while (!rxq_push && lat < 3000) begin @(posedge clk); #1; lat++; end
        chk(lat == exp_lat, "R9", $sformatf("push latency len=%0d", len), lat, exp_lat);
        chk(rxq_page == 2'(pg) && rx_irq, "R9", "push page/irq", int'(rxq_page), pg);
        @(posedge clk); #1;
        chk(!rxq_push && irq_cnt == irq0 + 1, "R9", "single pulse", irq_cnt - irq0, 1);
        check_record(len, strip);
    endtask

    task automatic t_refused(input bit en, input bit srst, input bit full, input string req);
        int p0, u0;
        pulse_ctl(1);
        p0 = push_cnt; u0 = int'(used);
        rx_enable = en; rx_soft_reset = srst; full_force = full;
        fill(30, 5);
        for (int i = 0; i < 30; i++) drive_byte(fbuf[i], i == 29);
        end_stream();
        repeat (20) @(posedge clk); #1;
        chk(wr_cnt == 0, req, "no writes", wr_cnt, 0);
        chk(push_cnt == p0 && int'(used) == u0, req, "no push/alloc", push_cnt - p0, 0);
        rx_enable = 1'b1; rx_soft_reset = 1'b0; full_force = 1'b0;
    endtask

    task automatic t_oversize(input int len, input bit strip);
        int p0, r0, pg;
        pulse_ctl(0);
        pg = lowest_free();
        p0 = push_cnt; r0 = ret_cnt;
        strip_crc = strip;
        fill(len, 9);
        for (int i = 0; i < len; i++) drive_byte(fbuf[i], i == len - 1);
        end_stream();
        repeat (20) @(posedge clk); #1;
        chk(push_cnt == p0, "R8", $sformatf("no push len=%0d", len), push_cnt - p0, 0);
        chk(ret_cnt == r0 + 1 && ret_page_cap == 2'(pg), "R8", "page returned",
            int'(ret_page_cap), pg);
        chk(used == 4'h0, "R8", "page free again", int'(used), 0);
    endtask

    task automatic t_stray();
        int p0;
        pulse_ctl(0);
        pulse_ctl(1);
        p0 = push_cnt;
        strip_crc = 1'b1;
        fill(100, 3);
        build_expected(100, 1'b1);
        for (int i = 0; i < 100; i++) drive_byte(fbuf[i], i == 99);
        for (int i = 0; i < 20; i++) drive_byte(8'hAA, i == 19);
        end_stream();
        repeat (40) @(posedge clk); #1;
        chk(push_cnt == p0 + 1, "R10", "one push only", push_cnt - p0, 1);
        chk(used == 4'h1, "R10", "one page taken", int'(used), 1);
        check_record(100, 1'b1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(!alloc_req && !mem_we && !pg_ret_valid && !rxq_push && !rx_irq, "R11",
            "outputs in reset", int'({alloc_req, mem_we, pg_ret_valid, rxq_push, rx_irq}), 0);
        rst_n = 1'b1;
        rx_enable = 1'b1;
        @(posedge clk); #1;
        chk(!alloc_req && !mem_we && !rxq_push && !rx_irq, "R11", "outputs after reset", 0, 0);

        t_frame(10, 1'b0, 1);     // short even, CRC kept
        t_frame(17, 1'b0, 2);     // short odd
        t_frame(63, 1'b1, 3);     // one pad byte, stripped
        t_frame(1, 1'b0, 4);      // single byte
        t_frame(64, 1'b0, 5);     // exactly minimum
        t_frame(101, 1'b0, 6);    // long odd, held byte after CRC
        t_frame(100, 1'b1, 7);    // long even, stripped
        t_frame(1519, 1'b0, 8);   // long flag and odd
        t_frame(2043, 1'b1, 9);   // count exactly 2048

        t_refused(1'b0, 1'b0, 1'b0, "R1");
        t_refused(1'b1, 1'b1, 1'b0, "R1");
        t_refused(1'b1, 1'b0, 1'b1, "R2");

        t_oversize(2040, 1'b0);   // overflow on the last byte
        t_oversize(2045, 1'b1);   // overflow mid-frame

        t_stray();
        t_frame(20, 1'b0, 11);    // normal operation after a stray frame

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule